// File: doc/BRIEF.md
# Object Handle Hash Lookup Unit

This block turns a 32-bit object name, submitted on one of the DMA channels, into the context word kept for that object in an on-chip hash table. The table index comes from folding the four name bytes together with XOR and then mixing in the channel number. Each table entry is a pair of words. The first word is the stored object name and the second is the context word. Software fills entries through a simple word write port. The lookup engine takes one request at a time and answers after a fixed number of cycles.

A response reports either a hit, with the context fields decoded, or a failure. Every failed lookup is diverted into a small first-word-fall-through error log, together with its channel, its name and a reason code, instead of being dropped. A failure can be a mismatched or unused entry, a name that is too small, or a context that names a class the hardware does not have. If the log is full, a sticky overflow flag records that an error was lost.

Top module: `obj_hash_lookup`

## Requirements
- R1: The table index is lk_name[31:24] ^ lk_name[23:16] ^ lk_name[15:8] ^ lk_name[7:0] ^ lk_chan (zero-extended to 8 bits). The write port address is {index, sel}: sel=0 writes the entry's name word and sel=1 writes its context word.
- R2: A request is accepted on a clock edge where lk_valid and lk_ready are both high. rsp_valid is then high for exactly one cycle, following the second edge after the accepting edge, provided no write conflict occurs (see R11).
- R3: lk_ready is high when the block is idle. It is low from the accepting edge until the response is presented.
- R4: On a hit (rsp_hit=1), the context word is decoded as follows: rsp_chan is bits [31:24], rsp_render is bit 23 (1 = render object, 0 = software object), rsp_class is bits [20:16] and rsp_offset is bits [15:0]. For example, 0x00C70400 gives channel 0, render 1, class 7 and offset 0x0400.
- R5: If the stored name differs from the requested name, or the entry's name word has not been written since reset, the response has rsp_hit=0 and all field outputs at zero. The error log then receives the request's channel, its name and code 0.
- R6: A lookup whose name is 4096 or less gives rsp_hit=0 and logs code 1.
- R7: A name-word write with data of 4096 or less does not change the table. wr_reject pulses for one cycle after that write edge. A name of 4097 is accepted.
- R8: A matching entry whose class field (context bits [22:16]) lies outside 0x40..0x5F, or whose class ID is 0x00, 0x0F, 0x13, 0x16, 0x18-0x1B or 0x1D-0x1F, gives rsp_hit=0 and logs code 2. Other IDs, for example 0x1C, give a hit.
- R9: The error log holds 16 records in arrival order. The head is shown on err_chan, err_name and err_code while err_valid is high, and a pulse on err_pop removes the head.
- R10: A record that arrives while the log is full, with no pop in the same cycle, is discarded. err_overflow then goes high and stays high until reset.
- R11: A write to the index of a lookup that is about to read the table takes priority. That lookup's response is delayed by exactly one cycle and reflects the newly written word.
- R12: After reset, lk_ready=1, rsp_valid=0, err_valid=0, err_overflow=0, wr_reject=0, and every entry counts as unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table word write strobe |
| wr_addr | input | 9 | Word address {index, sel} |
| wr_data | input | 32 | Word to write |
| wr_reject | output | 1 | Pulse: name write refused |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_chan | input | 3 | DMA channel of the request |
| lk_name | input | 32 | Object name to resolve |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Lookup resolved to a usable object |
| rsp_chan | output | 8 | Context channel field |
| rsp_render | output | 1 | Render/software flag |
| rsp_class | output | 5 | Hardware class ID |
| rsp_offset | output | 16 | Instance memory offset |
| err_valid | output | 1 | Error log not empty |
| err_pop | input | 1 | Remove head of error log |
| err_chan | output | 3 | Channel of head record |
| err_name | output | 32 | Name of head record |
| err_code | output | 2 | Reason of head record (0 miss, 1 bad name, 2 bad class) |
| err_overflow | output | 1 | Sticky: an error record was lost |

## Verification
If the valid-bit array is corrupted, the block answers a lookup of a never-written entry with a hit, or answers a freshly written one with a miss and a code-0 log record. Either shows at the ports within three cycles of the request. A stuck pipeline stage shows up as a missing or late rsp_valid pulse, or as lk_ready failing to return, so the latency is measured on every lookup. Errors in the log pointers or the count show up as reordered or duplicated records, or as an overflow flag set before the seventeenth pending error. These faults can only be seen when the log is drained, so the bench compares the whole drained sequence.

// File: rtl/ohl_pkg.sv
package ohl_pkg;

  localparam int OHL_WORD_W = 32;
  localparam int OHL_CODE_W = 2;

  typedef enum logic [OHL_CODE_W-1:0] {
    ERR_MISS  = 2'd0,
    ERR_NAME  = 2'd1,
    ERR_CLASS = 2'd2
  } err_code_e;

  // Hardware class IDs that exist on the rendering side.
  function automatic logic class_is_legal(input logic [4:0] id);
    case (id)
      5'h00, 5'h0F, 5'h13, 5'h16,
      5'h18, 5'h19, 5'h1A, 5'h1B,
      5'h1D, 5'h1E, 5'h1F: class_is_legal = 1'b0;
      default:             class_is_legal = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/ohl_table_ram.sv
// One-write, one-read synchronous RAM with registered read data.
module ohl_table_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ohl_err_fifo.sv
// First-word-fall-through error log with a sticky overflow flag.
module ohl_err_fifo #(
  parameter int WIDTH = 37,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             not_empty,
  output logic             overflow
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    count;
  logic             full, do_pop, do_push;

  assign full      = (count == CW'(DEPTH));
  assign not_empty = (count != '0);
  assign do_pop    = pop && not_empty;
  assign do_push   = push && (!full || do_pop);
  assign dout      = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && !do_push) overflow <= 1'b1;
    end
  end

  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r10_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full);

endmodule

// File: rtl/ohl_ctx_decode.sv
// Splits a context word into its fields and judges the class field.
module ohl_ctx_decode
  import ohl_pkg::*;
(
  input  logic [OHL_WORD_W-1:0] ctx,
  output logic [7:0]            chan,
  output logic                  render,
  output logic [4:0]            class_id,
  output logic [15:0]           offset,
  output logic                  class_ok
);

  logic [6:0] class_field;

  assign chan        = ctx[31:24];
  assign render      = ctx[23];
  assign class_field = ctx[22:16];
  assign class_id    = class_field[4:0];
  assign offset      = ctx[15:0];
  assign class_ok    = (class_field[6:5] == 2'b10) && class_is_legal(class_id);

endmodule

// File: rtl/obj_hash_lookup.sv
module obj_hash_lookup
  import ohl_pkg::*;
#(
  parameter int CHAN_W    = 3,
  parameter int IDX_W     = 8,
  parameter int NAME_MIN  = 4096,
  parameter int ERR_DEPTH = 16,
  localparam int DEPTH    = 1 << IDX_W,
  localparam int CHUNKS   = OHL_WORD_W / IDX_W,
  localparam int REC_W    = CHAN_W + OHL_WORD_W + OHL_CODE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W:0]        wr_addr,
  input  logic [OHL_WORD_W-1:0] wr_data,
  output logic                  wr_reject,
  input  logic                  lk_valid,
  output logic                  lk_ready,
  input  logic [CHAN_W-1:0]     lk_chan,
  input  logic [OHL_WORD_W-1:0] lk_name,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [7:0]            rsp_chan,
  output logic                  rsp_render,
  output logic [4:0]            rsp_class,
  output logic [15:0]           rsp_offset,
  output logic                  err_valid,
  input  logic                  err_pop,
  output logic [CHAN_W-1:0]     err_chan,
  output logic [OHL_WORD_W-1:0] err_name,
  output logic [OHL_CODE_W-1:0] err_code,
  output logic                  err_overflow
);

  localparam logic [OHL_WORD_W-1:0] MIN_NAME = OHL_WORD_W'(NAME_MIN);

  // ---------------- index fold ----------------
  logic [IDX_W-1:0] fold [CHUNKS+1];
  assign fold[0] = IDX_W'(lk_chan);
  for (genvar g = 0; g < CHUNKS; g++) begin : g_fold
    assign fold[g+1] = fold[g] ^ lk_name[g*IDX_W +: IDX_W];
  end

  // ---------------- write side ----------------
  logic             wr_is_name, wr_name_ok;
  logic [IDX_W-1:0] wr_idx;
  logic [1:0]       bank_we;
  logic [DEPTH-1:0] used;

  assign wr_idx     = wr_addr[IDX_W:1];
  assign wr_is_name = !wr_addr[0];
  assign wr_name_ok = wr_data > MIN_NAME;
  assign bank_we[0] = wr_en && wr_is_name && wr_name_ok;
  assign bank_we[1] = wr_en && !wr_is_name;

  always_ff @(posedge clk) begin
    if (rst) begin
      used      <= '0;
      wr_reject <= 1'b0;
    end else begin
      wr_reject <= wr_en && wr_is_name && !wr_name_ok;
      if (bank_we[0]) used[wr_idx] <= 1'b1;
    end
  end

  // ---------------- pipeline ----------------
  logic                  s1_v, s2_v;
  logic [IDX_W-1:0]      s1_idx;
  logic [OHL_WORD_W-1:0] s1_name, s2_name;
  logic [CHAN_W-1:0]     s1_chan, s2_chan;
  logic                  s2_used;
  logic                  conflict, s1_go, accept;

  assign lk_ready = !s1_v && !s2_v;
  assign accept   = lk_valid && lk_ready;
  assign conflict = wr_en && (wr_idx == s1_idx);
  assign s1_go    = s1_v && !conflict;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      if (accept)     s1_v <= 1'b1;
      else if (s1_go) s1_v <= 1'b0;
      s2_v <= s1_go;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_idx  <= fold[CHUNKS];
      s1_name <= lk_name;
      s1_chan <= lk_chan;
    end
    if (s1_go) begin
      s2_name <= s1_name;
      s2_chan <= s1_chan;
      s2_used <= used[s1_idx];
    end
  end

  // Two banks: bank 0 holds names, bank 1 holds contexts.
  logic [OHL_WORD_W-1:0] bank_q [2];
  for (genvar b = 0; b < 2; b++) begin : g_bank
    ohl_table_ram #(.WIDTH(OHL_WORD_W), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .we    (bank_we[b]),
      .waddr (wr_idx),
      .wdata (wr_data),
      .re    (s1_go),
      .raddr (s1_idx),
      .rdata (bank_q[b])
    );
  end

  // ---------------- compare and respond ----------------
  logic [7:0]  d_chan;
  logic        d_render, d_class_ok;
  logic [4:0]  d_class;
  logic [15:0] d_offset;

  ohl_ctx_decode u_dec (
    .ctx      (bank_q[1]),
    .chan     (d_chan),
    .render   (d_render),
    .class_id (d_class),
    .offset   (d_offset),
    .class_ok (d_class_ok)
  );

  logic      bad_name, match, good, err_push;
  err_code_e code;

  assign bad_name = !(s2_name > MIN_NAME);
  assign match    = s2_used && (bank_q[0] == s2_name);
  assign good     = !bad_name && match && d_class_ok;
  assign err_push = s2_v && !good;

  always_comb begin
    if (bad_name)   code = ERR_NAME;
    else if (!match) code = ERR_MISS;
    else             code = ERR_CLASS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_chan   <= '0;
      rsp_render <= 1'b0;
      rsp_class  <= '0;
      rsp_offset <= '0;
    end else begin
      rsp_valid  <= s2_v;
      rsp_hit    <= s2_v && good;
      rsp_chan   <= (s2_v && good) ? d_chan   : '0;
      rsp_render <= s2_v && good && d_render;
      rsp_class  <= (s2_v && good) ? d_class  : '0;
      rsp_offset <= (s2_v && good) ? d_offset : '0;
    end
  end

  // ---------------- error log ----------------
  logic [REC_W-1:0] rec_in, rec_out;
  assign rec_in = {s2_chan, s2_name, code};

  ohl_err_fifo #(.WIDTH(REC_W), .DEPTH(ERR_DEPTH)) u_log (
    .clk       (clk),
    .rst       (rst),
    .push      (err_push),
    .din       (rec_in),
    .pop       (err_pop),
    .dout      (rec_out),
    .not_empty (err_valid),
    .overflow  (err_overflow)
  );

  assign err_chan = rec_out[REC_W-1 -: CHAN_W];
  assign err_name = rec_out[OHL_CODE_W +: OHL_WORD_W];
  assign err_code = rec_out[OHL_CODE_W-1:0];

  // ---------------- assertions ----------------
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> !lk_ready);

  a_r2_read_then_respond: assert property (@(posedge clk) disable iff (rst)
    s2_v |=> rsp_valid);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r11_no_read_on_write: assert property (@(posedge clk) disable iff (rst)
    (s1_go && wr_en) |-> (wr_idx != s1_idx));

  a_r5_miss_logged: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> err_valid);

  a_r4_miss_fields_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_offset == '0 && rsp_class == '0));

endmodule

// File: tb/obj_hash_lookup_tb.sv
module obj_hash_lookup_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [8:0]  wr_addr;
  logic [31:0] wr_data;
  logic        wr_reject;
  logic        lk_valid, lk_ready;
  logic [2:0]  lk_chan;
  logic [31:0] lk_name;
  logic        rsp_valid, rsp_hit, rsp_render;
  logic [7:0]  rsp_chan;
  logic [4:0]  rsp_class;
  logic [15:0] rsp_offset;
  logic        err_valid, err_pop, err_overflow;
  logic [2:0]  err_chan;
  logic [31:0] err_name;
  logic [1:0]  err_code;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  obj_hash_lookup u_dut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_reject(wr_reject),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_chan(lk_chan), .lk_name(lk_name),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_chan(rsp_chan),
    .rsp_render(rsp_render), .rsp_class(rsp_class), .rsp_offset(rsp_offset),
    .err_valid(err_valid), .err_pop(err_pop), .err_chan(err_chan),
    .err_name(err_name), .err_code(err_code), .err_overflow(err_overflow)
  );

  // captured response
  int          r_lat;
  logic        r_hit, r_render;
  logic [7:0]  r_chan;
  logic [4:0]  r_class;
  logic [15:0] r_offset;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] hidx(input logic [2:0] ch, input logic [31:0] nm);
    return nm[31:24] ^ nm[23:16] ^ nm[15:8] ^ nm[7:0] ^ {5'd0, ch};
  endfunction

  task automatic write_word(input logic [8:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_entry(input logic [2:0] ch, input logic [31:0] nm, input logic [31:0] ctx);
    write_word({hidx(ch, nm), 1'b0}, nm);
    write_word({hidx(ch, nm), 1'b1}, ctx);
  endtask

  // Issues one lookup; optionally writes a context word to cidx during the read cycle.
  task automatic lookup(input logic [2:0] ch, input logic [31:0] nm,
                        input bit conf, input logic [7:0] cidx, input logic [31:0] cdata);
    lk_valid = 1'b1; lk_chan = ch; lk_name = nm;
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0;
    chk(lk_ready == 1'b0, "R3", "ready low in flight", lk_ready, 0);
    if (conf) begin wr_en = 1'b1; wr_addr = {cidx, 1'b1}; wr_data = cdata; end
    r_lat = 1;
    while (!rsp_valid && r_lat < 10) begin
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      r_lat++;
    end
    r_hit = rsp_hit; r_chan = rsp_chan; r_render = rsp_render;
    r_class = rsp_class; r_offset = rsp_offset;
    chk(lk_ready == 1'b1, "R3", "ready back with response", lk_ready, 1);
    @(posedge clk); @(negedge clk);
    chk(rsp_valid == 1'b0, "R2", "response one cycle", rsp_valid, 0);
  endtask

  task automatic expect_err(input string req, input logic [1:0] code,
                            input logic [2:0] ch, input logic [31:0] nm);
    chk(err_valid == 1'b1, req, "log not empty", err_valid, 1);
    chk(err_code == code, req, "log code", err_code, code);
    chk(err_chan == ch && err_name == nm, req, "log chan/name",
        {err_chan, err_name}, {ch, nm});
    err_pop = 1'b1; @(posedge clk); @(negedge clk); err_pop = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(lk_ready == 1'b1, "R12", "ready after reset", lk_ready, 1);
    chk(rsp_valid == 1'b0 && err_valid == 1'b0, "R12", "no rsp/err after reset",
        {rsp_valid, err_valid}, 0);
    chk(err_overflow == 1'b0 && wr_reject == 1'b0, "R12", "flags clear",
        {err_overflow, wr_reject}, 0);
  endtask

  task automatic t_unused;
    lookup(3'd0, 32'h01020304, 0, 8'd0, 32'd0);
    chk(r_hit == 1'b0, "R12", "unused entry misses", r_hit, 0);
    chk(r_lat == 3, "R2", "miss latency", r_lat, 3);
    expect_err("R5", 2'd0, 3'd0, 32'h01020304);
  endtask

  task automatic t_hit;
    write_entry(3'd0, 32'h01020304, 32'h00C70400);
    lookup(3'd0, 32'h01020304, 0, 8'd0, 32'd0);
    chk(r_lat == 3, "R2", "hit latency", r_lat, 3);
    chk(r_hit == 1'b1, "R1", "hit at folded index 4", r_hit, 1);
    chk({r_chan, r_render, r_class, r_offset} == {8'h00, 1'b1, 5'h07, 16'h0400},
        "R4", "decoded fields", {r_chan, r_render, r_class, r_offset},
        {8'h00, 1'b1, 5'h07, 16'h0400});
    chk(err_valid == 1'b0, "R5", "hit logs nothing", err_valid, 0);
  endtask

  task automatic t_channel;
    write_entry(3'd5, 32'hDEADBEEF, 32'h0551ABCD);
    lookup(3'd5, 32'hDEADBEEF, 0, 8'd0, 32'd0);
    chk(r_hit && r_chan == 8'h05 && !r_render && r_class == 5'h11 && r_offset == 16'hABCD,
        "R4", "second context", {r_hit, r_chan, r_render, r_class, r_offset},
        {1'b1, 8'h05, 1'b0, 5'h11, 16'hABCD});
    lookup(3'd4, 32'hDEADBEEF, 0, 8'd0, 32'd0);
    chk(r_hit == 1'b0, "R1", "channel mixes into index", r_hit, 0);
    expect_err("R5", 2'd0, 3'd4, 32'hDEADBEEF);
  endtask

  task automatic t_mismatch;
    lookup(3'd0, 32'h11110004, 0, 8'd0, 32'd0);
    chk(r_hit == 1'b0 && r_offset == 16'd0, "R5", "colliding name misses",
        {r_hit, r_offset}, 0);
    expect_err("R5", 2'd0, 3'd0, 32'h11110004);
  endtask

  task automatic t_names;
    lookup(3'd0, 32'h00001000, 0, 8'd0, 32'd0);
    chk(r_hit == 1'b0, "R6", "name 4096 refused", r_hit, 0);
    expect_err("R6", 2'd1, 3'd0, 32'h00001000);
    write_entry(3'd0, 32'h00001001, 32'h00C10000);
    lookup(3'd0, 32'h00001001, 0, 8'd0, 32'd0);
    chk(r_hit == 1'b1 && r_class == 5'h01, "R7", "name 4097 accepted",
        {r_hit, r_class}, {1'b1, 5'h01});
  endtask

  task automatic t_badwrite;
    wr_en = 1'b1; wr_addr = {8'd4, 1'b0}; wr_data = 32'h00000800;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk(wr_reject == 1'b1, "R7", "reject pulse", wr_reject, 1);
    @(posedge clk); @(negedge clk);
    chk(wr_reject == 1'b0, "R7", "reject one cycle", wr_reject, 0);
    lookup(3'd0, 32'h01020304, 0, 8'd0, 32'd0);
    chk(r_hit == 1'b1 && r_offset == 16'h0400, "R7", "table unchanged",
        {r_hit, r_offset}, {1'b1, 16'h0400});
  endtask

  task automatic t_class;
    write_entry(3'd2, 32'h33334444, 32'h02CF0010);
    lookup(3'd2, 32'h33334444, 0, 8'd0, 32'd0);
    chk(r_hit == 1'b0, "R8", "class 0x0F refused", r_hit, 0);
    expect_err("R8", 2'd2, 3'd2, 32'h33334444);
    write_entry(3'd3, 32'h55556666, 32'h035C0200);
    lookup(3'd3, 32'h55556666, 0, 8'd0, 32'd0);
    chk(r_hit && r_class == 5'h1C && r_offset == 16'h0200 && r_chan == 8'h03, "R8",
        "class 0x1C accepted", {r_hit, r_class, r_offset}, {1'b1, 5'h1C, 16'h0200});
    write_entry(3'd6, 32'h0A0B0C0D, 32'h06670000);
    lookup(3'd6, 32'h0A0B0C0D, 0, 8'd0, 32'd0);
    chk(r_hit == 1'b0, "R8", "class field 0x67 refused", r_hit, 0);
    expect_err("R8", 2'd2, 3'd6, 32'h0A0B0C0D);
  endtask

  task automatic t_conflict;
    write_entry(3'd0, 32'h77770001, 32'h00C10001);
    lookup(3'd0, 32'h77770001, 1, 8'd1, 32'h00C20002);
    chk(r_lat == 4, "R11", "stall one cycle", r_lat, 4);
    chk(r_hit && r_class == 5'h02 && r_offset == 16'h0002, "R11", "sees new context",
        {r_hit, r_class, r_offset}, {1'b1, 5'h02, 16'h0002});
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 16; i++) lookup(3'd1, 32'h20000000 + i, 0, 8'd0, 32'd0);
    chk(err_overflow == 1'b0, "R10", "no overflow at 16", err_overflow, 0);
    lookup(3'd1, 32'h20000010, 0, 8'd0, 32'd0);
    chk(err_overflow == 1'b1, "R10", "overflow at 17", err_overflow, 1);
    for (int i = 0; i < 16; i++) begin
      if (err_code != 2'd0 || err_name != 32'h20000000 + i || err_chan != 3'd1)
        chk(0, "R9", "log order", err_name, 32'h20000000 + i);
      err_pop = 1'b1; @(posedge clk); @(negedge clk); err_pop = 1'b0;
    end
    chk(1, "R9", "log order", 0, 0);
    chk(err_valid == 1'b0, "R10", "17th record dropped", err_valid, 0);
    @(posedge clk); @(negedge clk);
    chk(err_overflow == 1'b1, "R10", "overflow sticky", err_overflow, 1);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    lk_valid = 1'b0; lk_chan = '0; lk_name = '0; err_pop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset;
    t_unused;
    t_hit;
    t_channel;
    t_mismatch;
    t_names;
    t_badwrite;
    t_class;
    t_conflict;
    t_overflow;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule